// File: doc/BRIEF.md
# Serial Configuration Bitstream Streamer

This block is the readout side of a serial configuration memory. It holds a fixed bitstream in an internal bit array and shifts it out one bit per rising edge of a configuration clock. A programmable logic device samples each bit on that edge. An active-low reset/output-enable input clears the read address. An active-low chip select gates both counting and output drive. A serial-enable input must be high for any streaming to take place. The data output and the configuration clock pin are modelled as a value plus a separate drive-enable.

When reset/output-enable is released, the level of chip select sets the device's role. If chip select is low, the device becomes the chain master and produces the configuration clock from a divider on the system clock. If chip select is high, the device becomes a follower and advances on a synchronised external clock.

When the whole stream has been sent, the active-low cascade output falls and the data output stops driving. Wiring the cascade output to the next device's chip select hands the clock over to that device, so the devices in a chain stream one after another. A power-on timer holds the block idle after system reset and then raises a ready flag.

Top module: `cfg_bit_streamer`

## Requirements
- R1: After `rst_ni` is released, `ready_o` stays low for exactly POR_CYCLES rising clock edges and is high from then on. While `ready_o` is low, `data_oe_o` and `dclk_o` are low and the read address is zero.
- R2: While `oe_rst_ni` is low, `data_oe_o` is low whatever `cs_ni` is. One cycle later the read address is zero and `casc_no` is high. The next stream therefore begins again at address 0.
- R3: The role is the level of `cs_ni` in the last cycle of reset, that is, while `oe_rst_ni` is low or `ready_o` is low. Low selects master, which drives the clock pin (`dclk_oe_o` = 1). High selects follower (`dclk_oe_o` = 0).
- R4: While `cs_ni` is high, `data_oe_o` is low and the address does not change. Once `cs_ni` goes low, streaming carries on from the held address.
- R5: The bit stored at address a is bit (a mod 32) of the parameter PATTERN. Reading begins at address 0. While streaming, `data_o` shows the bit at the current address, and each clock rise moves the address up by exactly one.
- R6: In the master role while streaming, `dclk_o` is a square wave with a period of 2*DIV_HALF system clocks, and the address steps on the edge where `dclk_o` rises. While `oe_rst_ni` is low, and after the stream ends, `dclk_o` is held low.
- R7: In the follower role, a rising edge on `dclk_i` advances the address 2 to 3 system clocks later, after a two-stage synchroniser.
- R8: Once DEPTH bits have been stepped out, `casc_no` goes low and `data_oe_o` goes low in the same cycle. The block then stays in this state, with no further steps, until `oe_rst_ni` is taken low.
- R9: While `ser_en_i` is low, `data_oe_o` is low and the address does not move. When `ser_en_i` returns high, streaming resumes from the held address.
- R10: When two devices are chained, with the first device's `casc_no` driving the second device's `cs_ni` and both sharing one clock, the data seen is the first stream followed by the second. The two `data_oe_o` outputs are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| oe_rst_ni | input | 1 | Low: clear address and tri-state; high: output enable |
| cs_ni | input | 1 | Active-low chip select; also sets the role at reset release |
| ser_en_i | input | 1 | Streaming permitted while high |
| dclk_i | input | 1 | Configuration clock from outside, used by a follower |
| dclk_o | output | 1 | Configuration clock value driven by a master |
| dclk_oe_o | output | 1 | Drive enable for the clock pin (master role) |
| data_o | output | 1 | Serial data bit |
| data_oe_o | output | 1 | Drive enable for the data pin |
| casc_no | output | 1 | Active-low cascade: low once the stream is finished |
| ready_o | output | 1 | Power-on period finished |

## Verification
The stream is tried in several ways. It runs uninterrupted in the master role, which confirms the bit order and the clock period. It is broken by a deselect and by a serial-enable drop, and in both cases the capture must continue from the held address with no lost or repeated bit. It is cut by a reset mid-stream, and the capture must then start again at address 0. Finally, two followers share a bench clock and a cascade link. Clock pulses sent while the chain is deselected must not move either device. The captured stream must be the first pattern followed directly by the second, which separates a correct hand-off from one that skips, repeats or overlaps a bit.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;
  typedef enum logic {
    ROLE_FOLLOWER = 1'b0,
    ROLE_MASTER   = 1'b1
  } role_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cfg_por_timer.sv
module cfg_por_timer #(
  parameter int unsigned POR_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(POR_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_o <= 1'b0;
    end else if (!ready_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(POR_CYCLES - 1)) ready_o <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_clk_unit.sv
module cfg_clk_unit
  import cfg_stream_pkg::*;
#(
  parameter int unsigned DIV_HALF = 4,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic run_i,
  input  logic dclk_i,
  output logic dclk_o,
  output logic rise_o
);
  localparam int unsigned DW = cnt_width(DIV_HALF);

  logic [DW-1:0]     div_q;
  logic              dclk_q;
  logic [SYNC_LEN:0] sync_q;
  logic              div_wrap;
  logic              master_rise;
  logic              follower_rise;

  assign div_wrap = (div_q == DW'(DIV_HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      dclk_q <= 1'b0;
    end else if (!(run_i && master_i)) begin
      div_q  <= '0;
      dclk_q <= 1'b0;
    end else if (div_wrap) begin
      div_q  <= '0;
      dclk_q <= ~dclk_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // extra stage past the synchroniser holds the previous level for edge detect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_LEN-1:0], dclk_i};
  end

  assign master_rise   = run_i && div_wrap && !dclk_q;
  assign follower_rise = sync_q[SYNC_LEN-1] && !sync_q[SYNC_LEN];

  assign dclk_o = dclk_q;
  assign rise_o = master_i ? master_rise : follower_rise;
endmodule

// File: rtl/cfg_bit_rom.sv
module cfg_bit_rom #(
  parameter int unsigned DEPTH   = 64,
  parameter logic [31:0] PATTERN = 32'h0,
  parameter int unsigned AW      = 7
) (
  input  logic [AW-1:0] addr_i,
  output logic          bit_o
);
  localparam int unsigned SLOTS = 2 ** AW;

  logic [SLOTS-1:0] mem;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < DEPTH) begin : g_used
      assign mem[g] = PATTERN[g % 32];
    end else begin : g_pad
      assign mem[g] = 1'b0;
    end
  end

  assign bit_o = mem[addr_i];
endmodule

// File: rtl/cfg_bit_streamer.sv
module cfg_bit_streamer
  import cfg_stream_pkg::*;
#(
  parameter int unsigned DEPTH      = 64,
  parameter logic [31:0] PATTERN    = 32'hC3A5_0F96,
  parameter int unsigned DIV_HALF   = 4,
  parameter int unsigned POR_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_rst_ni,
  input  logic cs_ni,
  input  logic ser_en_i,
  input  logic dclk_i,
  output logic dclk_o,
  output logic dclk_oe_o,
  output logic data_o,
  output logic data_oe_o,
  output logic casc_no,
  output logic ready_o
);
  localparam int unsigned AW = $clog2(DEPTH + 1);

  logic          ready;
  logic          hold_rst;
  logic          done;
  logic          stream_en;
  logic          rise;
  logic          advance;
  logic          rom_bit;
  logic          is_master;
  role_e         role_q;
  logic [AW-1:0] addr_q;

  cfg_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ready_o(ready)
  );

  assign hold_rst = !ready || !oe_rst_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       role_q <= ROLE_FOLLOWER;
    else if (hold_rst) role_q <= cs_ni ? ROLE_FOLLOWER : ROLE_MASTER;
  end

  assign is_master = (role_q == ROLE_MASTER);
  assign done      = (addr_q == AW'(DEPTH));
  assign stream_en = !hold_rst && !cs_ni && ser_en_i && !done;

  cfg_clk_unit #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .master_i(is_master),
    .run_i   (stream_en),
    .dclk_i  (dclk_i),
    .dclk_o  (dclk_o),
    .rise_o  (rise)
  );

  assign advance = stream_en && rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_q <= '0;
    else if (hold_rst) addr_q <= '0;
    else if (advance)  addr_q <= addr_q + 1'b1;
  end

  cfg_bit_rom #(.DEPTH(DEPTH), .PATTERN(PATTERN), .AW(AW)) u_rom (
    .addr_i(addr_q),
    .bit_o (rom_bit)
  );

  assign data_oe_o = stream_en;
  assign data_o    = stream_en & rom_bit;
  assign dclk_oe_o = ready && is_master;
  assign casc_no   = !done;
  assign ready_o   = ready;
endmodule

// File: rtl/cfg_bit_streamer_chk.sv
module cfg_bit_streamer_chk #(
  parameter int unsigned AW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          oe_rst_ni,
  input logic          cs_ni,
  input logic          ser_en_i,
  input logic          dclk_o,
  input logic          data_oe_o,
  input logic          casc_no,
  input logic          ready_o,
  input logic [AW-1:0] addr_q
);
  AST_NOT_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (!data_oe_o && !dclk_o && addr_q == '0)); // R1
  AST_RST_TRISTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_rst_ni |-> !data_oe_o); // R2
  AST_RST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_rst_ni |=> (addr_q == '0 && casc_no)); // R2
  AST_DESEL_TRISTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !data_oe_o); // R4
  AST_DESEL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && oe_rst_ni && ready_o) |=> $stable(addr_q)); // R4
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_q != $past(addr_q)) |-> (addr_q == AW'($past(addr_q) + 1'b1) || addr_q == '0)); // R5
  AST_RST_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_rst_ni |=> !dclk_o); // R6
  AST_DONE_TRISTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !casc_no |-> !data_oe_o); // R8
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!casc_no && oe_rst_ni && ready_o) |=> !casc_no); // R8
  AST_SER_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_en_i |-> !data_oe_o); // R9
endmodule

bind cfg_bit_streamer cfg_bit_streamer_chk #(.AW($clog2(DEPTH + 1))) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .oe_rst_ni(oe_rst_ni),
  .cs_ni    (cs_ni),
  .ser_en_i (ser_en_i),
  .dclk_o   (dclk_o),
  .data_oe_o(data_oe_o),
  .casc_no  (casc_no),
  .ready_o  (ready_o),
  .addr_q   (addr_q)
);

// File: tb/sim_cfg_bit_streamer.sv
module sim_cfg_bit_streamer;
  localparam int          CLK_PERIOD = 10;
  localparam int          D0         = 12;
  localparam int          D1         = 9;
  localparam logic [31:0] P0         = 32'hB38E_55C1;
  localparam logic [31:0] P1         = 32'h6D2A_F0B7;
  localparam int          DIVH       = 2;
  localparam int          POR        = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oe_n = 1'b0;
  logic cs0_n = 1'b0;
  logic ser_en = 1'b1;
  logic ext_clk = 1'b0;

  logic dclk0, dclk_oe0, data0, data_oe0, casc0_n, ready0;
  logic dclk1, dclk_oe1, data1, data_oe1, casc1_n, ready1;

  int n_chk = 0;
  int n_err = 0;
  int overlap = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cfg_bit_streamer #(.DEPTH(D0), .PATTERN(P0), .DIV_HALF(DIVH), .POR_CYCLES(POR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .oe_rst_ni(oe_n), .cs_ni(cs0_n), .ser_en_i(ser_en),
    .dclk_i(ext_clk), .dclk_o(dclk0), .dclk_oe_o(dclk_oe0), .data_o(data0),
    .data_oe_o(data_oe0), .casc_no(casc0_n), .ready_o(ready0)
  );

  cfg_bit_streamer #(.DEPTH(D1), .PATTERN(P1), .DIV_HALF(DIVH), .POR_CYCLES(POR)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .oe_rst_ni(oe_n), .cs_ni(casc0_n), .ser_en_i(ser_en),
    .dclk_i(ext_clk), .dclk_o(dclk1), .dclk_oe_o(dclk_oe1), .data_o(data1),
    .data_oe_o(data_oe1), .casc_no(casc1_n), .ready_o(ready1)
  );

  always @(negedge clk) if (rst_n && data_oe0 && data_oe1) overlap++;

  function automatic logic exp_bit(input logic [31:0] p, input int a);
    return p[a % 32];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // capture n master bits starting at stream index first
  task automatic master_bits(input int first, input int n, input string req, input bit chk_period);
    int got = 0;
    int cyc = 0;
    int last = -1;
    bit period_done = 0;
    logic pd = data0;
    logic pc = dclk0;
    logic po = data_oe0;
    while (got < n && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (dclk0 && !pc) begin
        chk({req, " bit"}, int'(pd), int'(exp_bit(P0, first + got)));
        chk({req, " oe at sample"}, int'(po), 1);
        if (chk_period && last >= 0 && !period_done) begin
          chk("R6 clock period", cyc - last, 2 * DIVH);
          period_done = 1;
        end
        last = cyc;
        got++;
      end
      pc = dclk0;
      pd = data0;
      po = data_oe0;
    end
    chk({req, " bits captured"}, got, n);
  endtask

  task automatic start_master();
    oe_n = 1'b0;
    cs0_n = 1'b0;
    ser_en = 1'b1;
    repeat (3) @(negedge clk);
    oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_power_on();
    oe_n = 1'b0;
    cs0_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ready during reset", int'(ready0), 0);
    rst_n = 1'b1;
    repeat (POR - 1) @(posedge clk);
    @(negedge clk);
    chk("R1 ready low before period ends", int'(ready0), 0);
    chk("R1 no drive before ready", int'(data_oe0), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R1 ready after period", int'(ready0), 1);
    chk("R1 cascade idle", int'(casc0_n), 1);
  endtask

  task automatic t_master_full();
    start_master();
    chk("R3 master drives clock pin", int'(dclk_oe0), 1);
    chk("R3 follower does not drive clock", int'(dclk_oe1), 0);
    chk("R5 first bit at address 0", int'(data0), int'(exp_bit(P0, 0)));
    master_bits(0, D0, "R5 master stream", 1'b1);
    chk("R8 cascade low at end", int'(casc0_n), 0);
    chk("R8 data released at end", int'(data_oe0), 0);
    repeat (2) @(negedge clk);
    begin
      int hi = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (dclk0 || data_oe0 || casc0_n) hi++;
      end
      chk("R6 clock held low after end", hi, 0);
      chk("R8 no further output after end", hi, 0);
    end
  endtask

  task automatic t_reset_mid();
    start_master();
    master_bits(0, 5, "R2 pre-reset", 1'b0);
    oe_n = 1'b0;
    @(negedge clk);
    chk("R2 data released in reset", int'(data_oe0), 0);
    chk("R2 cascade high in reset", int'(casc0_n), 1);
    chk("R6 clock low in reset", int'(dclk0), 0);
    cs0_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 released with cs high", int'(data_oe0), 0);
    cs0_n = 1'b0;
    repeat (2) @(negedge clk);
    oe_n = 1'b1;
    @(negedge clk);
    master_bits(0, D0, "R2 restart from address 0", 1'b0);
  endtask

  task automatic t_deselect();
    int bad = 0;
    start_master();
    master_bits(0, 4, "R4 before deselect", 1'b0);
    cs0_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (data_oe0 || dclk0) bad++;
    end
    chk("R4 quiet while deselected", bad, 0);
    cs0_n = 1'b0;
    @(negedge clk);
    master_bits(4, D0 - 4, "R4 resume after deselect", 1'b0);
  endtask

  task automatic t_ser_en();
    int bad = 0;
    start_master();
    master_bits(0, 3, "R9 before disable", 1'b0);
    ser_en = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (data_oe0 || dclk0) bad++;
    end
    chk("R9 quiet while serial disabled", bad, 0);
    ser_en = 1'b1;
    @(negedge clk);
    master_bits(3, D0 - 3, "R9 resume after enable", 1'b0);
  endtask

  task automatic ext_pulse();
    ext_clk = 1'b1;
    repeat (4) @(negedge clk);
    ext_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_chain();
    int bad = 0;
    int seen_err = 0;
    oe_n = 1'b0;
    cs0_n = 1'b1;
    ser_en = 1'b1;
    ext_clk = 1'b0;
    repeat (3) @(negedge clk);
    oe_n = 1'b1;
    @(negedge clk);
    chk("R3 follower role with cs high", int'(dclk_oe0), 0);
    for (int i = 0; i < 5; i++) begin
      ext_pulse();
      if (data_oe0 || data_oe1) bad++;
    end
    chk("R4 follower frozen and released while deselected", bad, 0);
    cs0_n = 1'b0;
    for (int k = 0; k < D0 + D1; k++) begin
      logic e;
      logic got;
      @(negedge clk);
      e = (k < D0) ? exp_bit(P0, k) : exp_bit(P1, k - D0);
      got = data_oe0 ? data0 : data1;
      if (!(data_oe0 ^ data_oe1) || got !== e) begin
        seen_err++;
        $display("FAIL R10 chain bit %0d: actual %0d (oe %0d/%0d) expected %0d",
                 k, got, data_oe0, data_oe1, e);
      end
      ext_pulse();
    end
    n_chk++;
    if (seen_err != 0) n_err++;
    chk("R7 follower stream first device ended", int'(casc0_n), 0);
    chk("R7 follower stream second device ended", int'(casc1_n), 0);
    chk("R10 both released at end", int'(data_oe0 | data_oe1), 0);
    chk("R10 outputs never overlap", overlap, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_power_on();
    t_master_full();
    t_reset_mid();
    t_deselect();
    t_ser_en();
    t_chain();
    finish_run();
  end
endmodule